// File: doc/BRIEF.md
# PCI Data Parity Error Detector

This block watches the data phases seen at a PCI-style bus interface, checks even parity across the address/data bus, the byte-enable bus and the parity bit, and reports a failed check on the active-low parity-error line. The parity bit lags the data it covers by one clock. The error strobe appears one clock after that parity bit, which is two clocks after the covered data and byte enables. Which agent reports depends on the direction of the transfer: the target of a write or the initiator of a read.

The error line is a sustained tri-state signal. The block supplies a drive value and an output enable for an external pad. After its last low cycle it drives the line high for one clock, then turns the enable off so an external pull-up holds the line. A sticky status flag records every detected error, whether or not reporting on the line is enabled. Software clears the flag by writing a one to it, which arrives here as a one-cycle clear pulse.

Top module: `pci_parity_guard`

## Requirements
- R1: Parity is even. A phase is in error when the XOR of all 32 `ad_in` bits, the 4 `cbe_n_in` bits and the `par_in` value of the following clock equals 1.
- R2: For a checked phase in error that is captured in cycle k, `perr_n_out` is 0 and `perr_oe` is 1 during cycle k+2. Otherwise the line is not driven low in that cycle.
- R3: A phase is checked only when `irdy_n_in` and `trdy_n_in` are both 0 in cycle k. Wait states and address phases never produce an error indication or set the status.
- R4: A phase is checked only when `tgt_wr_in` (write, device is target) or `init_rd_in` (read, device is initiator) is 1 in cycle k. With both at 0 a parity failure is ignored.
- R5: The line is driven low only if `resp_en_in` was 1 in cycle k. The status flag is set for a checked error regardless of `resp_en_in`.
- R6: In the cycle after the last low cycle, the block drives the line high (`perr_oe`=1, `perr_n_out`=1). In the cycle after that, `perr_oe` is 0 unless a new error is due.
- R7: Errors in consecutive phases hold the line low in consecutive cycles, with no high cycle between them.
- R8: `par_err_stat` becomes 1 in cycle k+2 for a checked error and stays set. A `stat_clr` pulse in cycle c clears it from cycle c+1. When a set and a clear fall on the same edge, the set wins.
- R9: During and just after reset, `perr_oe` is 0, `perr_n_out` is 1 and `par_err_stat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data bus as sampled |
| cbe_n_in | input | 4 | Command/byte-enable bus as sampled |
| par_in | input | 1 | Parity bit for the previous clock's bus values |
| irdy_n_in | input | 1 | Initiator ready, active low |
| trdy_n_in | input | 1 | Target ready, active low |
| tgt_wr_in | input | 1 | Device is target of a write transfer |
| init_rd_in | input | 1 | Device is initiator of a read transfer |
| resp_en_in | input | 1 | Parity error response enable |
| stat_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| perr_n_out | output | 1 | Drive value for the parity-error line |
| perr_oe | output | 1 | Output enable for the parity-error line |
| par_err_stat | output | 1 | Sticky detected-parity-error flag |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a status set and a software clear. The bench issues the clear pulse in the clock after a failing phase, so the clear is sampled on the same edge that sets the flag, and it expects the flag to stay at 1. The second pair is the one-cycle drive-high park and a new error. The bench places failing phases back to back, and also one clean phase apart, and expects low-low in the first case and low-high-low in the second, with the enable held on throughout.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

   typedef enum logic [1:0] {
      LINE_IDLE = 2'd0,
      LINE_LOW  = 2'd1,
      LINE_PARK = 2'd2
   } line_st_e;

   typedef struct packed {
      logic sum;
      logic check;
      logic drive_ok;
   } stage1_t;

endpackage

// File: rtl/pcipar_fold.sv
module pcipar_fold #(
   parameter int AD_W       = 32,
   parameter int BYTE_W     = 8,
   parameter bit LANE_SPLIT = 1'b1
) (
   input  logic [AD_W-1:0]        ad_i,
   input  logic [AD_W/BYTE_W-1:0] cbe_i,
   output logic                   sum_o
);
   localparam int LANES = AD_W / BYTE_W;

   generate
      if (AD_W % BYTE_W != 0) begin : g_bad_width
         $error("pcipar_fold: AD_W must be a multiple of BYTE_W");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("pcipar_fold: at least one lane required");
      end

      if (LANE_SPLIT) begin : g_lanes
         logic [LANES-1:0] lane_sum;
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_sum[i] = (^ad_i[i*BYTE_W +: BYTE_W]) ^ cbe_i[i];
         end
         assign sum_o = ^lane_sum;
      end else begin : g_flat
         assign sum_o = ^{ad_i, cbe_i};
      end
   endgenerate
endmodule

// File: rtl/pcipar_align.sv
module pcipar_align
   import pcipar_pkg::*;
#(
   parameter int AD_W       = 32,
   parameter int BYTE_W     = 8,
   parameter bit LANE_SPLIT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AD_W-1:0]        ad_in,
   input  logic [AD_W/BYTE_W-1:0] cbe_n_in,
   input  logic                   par_in,
   input  logic                   irdy_n_in,
   input  logic                   trdy_n_in,
   input  logic                   tgt_wr_in,
   input  logic                   init_rd_in,
   input  logic                   resp_en_in,
   output logic                   err_evt,
   output logic                   drv_req
);
   localparam int LANES = AD_W / BYTE_W;

   logic    word_sum;
   logic    phase_ok;
   stage1_t s1_q;

   pcipar_fold #(
      .AD_W      (AD_W),
      .BYTE_W    (BYTE_W),
      .LANE_SPLIT(LANE_SPLIT)
   ) fold_i (
      .ad_i (ad_in),
      .cbe_i(cbe_n_in[LANES-1:0]),
      .sum_o(word_sum)
   );

   assign phase_ok = !irdy_n_in && !trdy_n_in && (tgt_wr_in || init_rd_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= '0;
      end else begin
         s1_q.sum      <= word_sum;
         s1_q.check    <= phase_ok;
         s1_q.drive_ok <= resp_en_in;
      end
   end

   assign err_evt = s1_q.check && (s1_q.sum ^ par_in);
   assign drv_req = err_evt && s1_q.drive_ok;

   assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |-> $past(!irdy_n_in && !trdy_n_in));

   assert_role_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |-> $past(tgt_wr_in || init_rd_in));
endmodule

// File: rtl/pcipar_line.sv
module pcipar_line
   import pcipar_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic drv_req,
   output logic perr_n_out,
   output logic perr_oe
);
   line_st_e st_q, st_d;

   always_comb begin
      if (drv_req)               st_d = LINE_LOW;
      else if (st_q == LINE_LOW) st_d = LINE_PARK;
      else                       st_d = LINE_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LINE_IDLE;
      else        st_q <= st_d;
   end

   assign perr_n_out = (st_q != LINE_LOW);
   assign perr_oe    = (st_q != LINE_IDLE);

   assert_low_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drv_req |=> (!perr_n_out && perr_oe));

   assert_park_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_n_out && !drv_req) |=> (perr_oe && perr_n_out));

   assert_release_after_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_oe) |-> $past(perr_n_out));

   assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_n_out && drv_req) |=> !perr_n_out);
endmodule

// File: rtl/pcipar_sticky.sv
module pcipar_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic stat_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stat_o <= 1'b0;
      else if (set_i) stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
   end

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> stat_o);

   assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o) |-> $past(clr_i));
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard #(
   parameter int AD_W       = 32,
   parameter int BYTE_W     = 8,
   parameter bit LANE_SPLIT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AD_W-1:0]        ad_in,
   input  logic [AD_W/BYTE_W-1:0] cbe_n_in,
   input  logic                   par_in,
   input  logic                   irdy_n_in,
   input  logic                   trdy_n_in,
   input  logic                   tgt_wr_in,
   input  logic                   init_rd_in,
   input  logic                   resp_en_in,
   input  logic                   stat_clr,
   output logic                   perr_n_out,
   output logic                   perr_oe,
   output logic                   par_err_stat
);
   logic err_evt;
   logic drv_req;

   pcipar_align #(
      .AD_W      (AD_W),
      .BYTE_W    (BYTE_W),
      .LANE_SPLIT(LANE_SPLIT)
   ) align_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ad_in     (ad_in),
      .cbe_n_in  (cbe_n_in),
      .par_in    (par_in),
      .irdy_n_in (irdy_n_in),
      .trdy_n_in (trdy_n_in),
      .tgt_wr_in (tgt_wr_in),
      .init_rd_in(init_rd_in),
      .resp_en_in(resp_en_in),
      .err_evt   (err_evt),
      .drv_req   (drv_req)
   );

   pcipar_line line_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .drv_req   (drv_req),
      .perr_n_out(perr_n_out),
      .perr_oe   (perr_oe)
   );

   pcipar_sticky sticky_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_evt),
      .clr_i (stat_clr),
      .stat_o(par_err_stat)
   );

   assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_out |-> $past(resp_en_in, 2));

   assert_low_implies_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_out |-> par_err_stat);
endmodule

// File: tb/pci_parity_guard_tb.sv
`timescale 1ns/1ps
module pci_parity_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par = 1'b0;
   logic        irdy_n = 1'b1, trdy_n = 1'b1;
   logic        tgt_wr = 1'b0, init_rd = 1'b0, resp_en = 1'b0, stat_clr = 1'b0;
   logic        perr_n_out, perr_oe, par_err_stat;

   always #2 clk = ~clk;

   pci_parity_guard dut_i (
      .clk(clk), .rst_n(rst_n), .ad_in(ad), .cbe_n_in(cbe_n), .par_in(par),
      .irdy_n_in(irdy_n), .trdy_n_in(trdy_n), .tgt_wr_in(tgt_wr),
      .init_rd_in(init_rd), .resp_en_in(resp_en), .stat_clr(stat_clr),
      .perr_n_out(perr_n_out), .perr_oe(perr_oe), .par_err_stat(par_err_stat)
   );

   typedef struct {
      int    tgt;
      bit    ev;
      bit    drv;
      string tag;
   } item_t;

   item_t sbq[$];
   bit    clr_hist[int];
   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   logic  nxt_par = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
      end
   endtask

   // Driver: one call is one clock; PAR for the previous call goes out now.
   task automatic phase(input logic [31:0] a, input logic [3:0] c, input bit bad,
                        input string tag, input bit ir = 0, input bit tr = 0,
                        input bit wt = 1, input bit ri = 0, input bit en = 1,
                        input bit clr = 0);
      bit ev;
      @(posedge clk); #1;
      ad = a; cbe_n = c; par = nxt_par;
      irdy_n = ir; trdy_n = tr; tgt_wr = wt; init_rd = ri;
      resp_en = en; stat_clr = clr;
      nxt_par = (^a) ^ (^c) ^ bad;
      clr_hist[cyc] = clr;
      ev = !ir && !tr && (wt || ri) && bad;
      sbq.push_back('{tgt: cyc + 2, ev: ev, drv: ev && en, tag: tag});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) phase(32'h0, 4'hF, 1'b0, tag, 1'b1, 1'b1, 1'b0);
   endtask

   // Monitor: expected line and status from the requirement timing.
   initial begin
      bit    exp_stat = 0;
      bit    prev_low = 0;
      bit    exp_low, exp_oe;
      item_t it;
      forever begin
         @(negedge clk);
         if (rst_n && sbq.size() > 0 && sbq[0].tgt == cyc) begin
            it = sbq.pop_front();
            exp_low = it.drv;
            exp_oe  = it.drv || prev_low;
            if (it.ev) exp_stat = 1'b1;
            else if (clr_hist.exists(cyc - 1) && clr_hist[cyc - 1]) exp_stat = 1'b0;
            check(it.tag, "perr_n_out", perr_n_out, !exp_low);
            check(prev_low && !it.drv ? "R6" : it.tag, "perr_oe", perr_oe, exp_oe);
            check(it.ev ? it.tag : "R8", "par_err_stat", par_err_stat, exp_stat);
            prev_low = exp_low;
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state while reset held, then just after release
      check("R9", "perr_oe in reset", perr_oe, 1'b0);
      check("R9", "perr_n_out in reset", perr_n_out, 1'b1);
      check("R9", "par_err_stat in reset", par_err_stat, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "perr_oe after reset", perr_oe, 1'b0);
      check("R9", "par_err_stat after reset", par_err_stat, 1'b0);

      // R1: clean phases over varied patterns produce nothing
      phase(32'h0000_0000, 4'h0, 0, "R1");
      phase(32'hFFFF_FFFF, 4'hF, 0, "R1");
      phase(32'hA5A5_5A5A, 4'h6, 0, "R1");
      phase(32'h0000_0001, 4'h0, 0, "R1");
      phase(32'h8000_0000, 4'h1, 0, "R1", 0, 0, 0, 1);
      // R2/R6: single error, then idle to observe park and release
      phase(32'h1234_5678, 4'h3, 1, "R2");
      idle(4, "R6");
      // R7: back-to-back errors, read initiator role
      phase(32'hDEAD_BEEF, 4'hA, 1, "R7", 0, 0, 0, 1);
      phase(32'hCAFE_F00D, 4'h5, 1, "R7", 0, 0, 0, 1);
      idle(3, "R6");
      // park cycle meets a new error: error, clean, error
      phase(32'h0F0F_0F0F, 4'h2, 1, "R2");
      phase(32'h0F0F_0F0F, 4'h2, 0, "R6");
      phase(32'hF0F0_F0F0, 4'h8, 1, "R2");
      idle(3, "R6");
      // R8: plain clear
      phase(32'h0, 4'hF, 0, "R8", 1, 1, 0, 0, 1, 1);
      idle(2, "R8");
      // R3: wait states and address-style phases with bad parity
      phase(32'h1111_1111, 4'h1, 1, "R3", 1, 0);
      phase(32'h2222_2222, 4'h2, 1, "R3", 0, 1);
      phase(32'h3333_3333, 4'h3, 1, "R3", 1, 1);
      idle(2, "R3");
      // R4: no reporting role
      phase(32'h4444_4444, 4'h4, 1, "R4", 0, 0, 0, 0);
      idle(2, "R4");
      // R5: enable off sets status but line stays released
      phase(32'h5555_5555, 4'h7, 1, "R5", 0, 0, 1, 0, 0);
      idle(3, "R5");
      phase(32'h0, 4'hF, 0, "R8", 1, 1, 0, 0, 1, 1);
      idle(2, "R8");
      // R8: clear sampled on the same edge as a set: set wins
      phase(32'h6666_6667, 4'hC, 1, "R8");
      phase(32'h0, 4'hF, 0, "R8", 1, 1, 0, 0, 1, 1);
      idle(3, "R8");
      phase(32'h0, 4'hF, 0, "R8", 1, 1, 0, 0, 1, 1);
      idle(3, "R8");
      // R1: single flipped byte-enable bit on otherwise clean data
      phase(32'h0000_00FF, 4'hE, 1, "R1", 0, 0, 0, 1);
      idle(4, "R1");
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule